// File: doc/BRIEF.md
# Banked Data Memory Access Unit

This block is the byte-wide data memory of a small microcontroller core. It holds 4096 bytes, split into sixteen banks of 256 bytes. The core hands it an 8-bit operand and a two-bit mode, and the block builds the 12-bit address from that pair. In direct mode the address comes from a bank register together with the operand. In indirect mode it comes from a pointer register. In access mode the operand reaches one fixed window, whatever bank is selected. That window is the low 128 bytes of bank 0 together with the top 128 bytes of bank 15.

The top 128 addresses hold the special function registers. Three of them are real registers that sit outside the byte array: a general output latch (PORTA), a bidirectional port latch (PORTB), and the direction register for that port. The core reads and writes them with ordinary data accesses. The bank and pointer registers are loaded through their own write ports. Reads are registered and return data one clock after the address is presented.

Top module: `banked_mem_unit`

## Requirements
- R1: With mode 00 (direct), the address is the low 4 bits of the bank register as bits 11:8 and the operand as bits 7:0.
- R2: With mode 01 (indirect), the address is the low 12 bits of the pointer register.
- R3: With mode 10 (access), operands 00h–7Fh address 000h–07Fh and operands 80h–FFh address F80h–FFFh, whatever the bank register holds.
- R4: Read data appears on rdData in the clock after the address is presented. A write takes effect on the rising edge while wrEn is 1. A read in the same cycle as a write to the same address returns the old content.
- R5: The bank register loads the low 4 bits of bankWrData, and the pointer register loads the low 12 bits of ptrWrData, on an edge where the matching enable is 1. The new value is used from the next cycle. Both registers reset to zero.
- R6: Address F80h is the PORTA latch. It resets to 00h, drives portaOut, and reads back its latch value.
- R7: Address F81h is the PORTB latch. A write always updates the latch, which drives portbOut and resets to 00h. A read returns portbIn for bits whose direction bit is 1 and the latch for bits whose direction bit is 0.
- R8: Address F93h is the direction register. It resets to FFh, drives portbDir, and is readable.
- R9: Mode 11 addresses memory exactly as direct mode does.
- R10: When wrEn is 0, a cycle leaves memory and the port registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Address mode: 00 direct, 01 indirect, 10 access, 11 as direct |
| operand | input | 8 | Operand from the instruction |
| wrEn | input | 1 | Data write enable |
| wrData | input | 8 | Data to write |
| rdData | output | 8 | Registered read data |
| bankWrEn | input | 1 | Bank register load enable |
| bankWrData | input | 8 | Bank register load value (low 4 bits used) |
| ptrWrEn | input | 1 | Pointer register load enable |
| ptrWrData | input | 16 | Pointer register load value (low 12 bits used) |
| portbIn | input | 8 | External PORTB pin levels |
| portaOut | output | 8 | PORTA latch |
| portbOut | output | 8 | PORTB output latch |
| portbDir | output | 8 | PORTB direction, 1 = input |

## Verification
The assertions assume that reset is held for at least one clock edge before any access. They also assume that the mode, operand and write inputs stay stable across each rising edge. The bench drives every input one time unit after a rising edge and holds it for the whole cycle, so each address is formed from settled values. It asserts reset first and issues no access until reset is released. It changes the bank and pointer registers only in cycles of their own, so a load and an access never share a cycle, except where the bench checks that a new value is used one cycle later.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'b00,
    MODE_INDIRECT = 2'b01,
    MODE_ACCESS   = 2'b10,
    MODE_SPARE    = 2'b11
  } accMode_e;

  typedef enum logic [1:0] {
    RD_MEM   = 2'd0,
    RD_PORTA = 2'd1,
    RD_PORTB = 2'd2,
    RD_TRIS  = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   memWr;
    logic   portaWr;
    logic   portbWr;
    logic   trisWr;
    rdSrc_e rdSel;
  } memCtrl_t;

endpackage

// File: rtl/bmu_ctrl.sv
module bmu_ctrl
  import bmu_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int OFF_W     = 8,
  parameter int BANK_IN_W = 8,
  parameter int PTR_IN_W  = 16,
  parameter int unsigned PORTA_ADDR = 'hF80,
  parameter int unsigned PORTB_ADDR = 'hF81,
  parameter int unsigned TRIS_ADDR  = 'hF93
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           mode,
  input  logic [OFF_W-1:0]     operand,
  input  logic                 wrEn,
  input  logic                 bankWrEn,
  input  logic [BANK_IN_W-1:0] bankWrData,
  input  logic                 ptrWrEn,
  input  logic [PTR_IN_W-1:0]  ptrWrData,
  output logic [ADDR_W-1:0]    addr,
  output memCtrl_t             ctrl
);

  localparam int BANK_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] PORTA_A = PORTA_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] PORTB_A = PORTB_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] TRIS_A  = TRIS_ADDR[ADDR_W-1:0];

  logic [BANK_W-1:0] bsrQ;
  logic [ADDR_W-1:0] fsrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bsrQ <= '0;
      fsrQ <= '0;
    end else begin
      if (bankWrEn) bsrQ <= bankWrData[BANK_W-1:0];
      if (ptrWrEn)  fsrQ <= ptrWrData[ADDR_W-1:0];
    end
  end

  // Address former: access mode folds the operand onto the two ends of memory.
  always_comb begin
    unique case (mode)
      MODE_INDIRECT: addr = fsrQ;
      MODE_ACCESS:   addr = {{BANK_W{operand[OFF_W-1]}}, operand};
      default:       addr = {bsrQ, operand};
    endcase
  end

  logic hitA, hitB, hitT;
  assign hitA = (addr == PORTA_A);
  assign hitB = (addr == PORTB_A);
  assign hitT = (addr == TRIS_A);

  always_comb begin
    ctrl.memWr   = wrEn && !(hitA || hitB || hitT);
    ctrl.portaWr = wrEn && hitA;
    ctrl.portbWr = wrEn && hitB;
    ctrl.trisWr  = wrEn && hitT;
    if (hitA)      ctrl.rdSel = RD_PORTA;
    else if (hitB) ctrl.rdSel = RD_PORTB;
    else if (hitT) ctrl.rdSel = RD_TRIS;
    else           ctrl.rdSel = RD_MEM;
  end

  // R1 / R9: direct and spare modes place the bank register on the upper bits
  p_direct_bank_r1: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_DIRECT || mode == MODE_SPARE) |-> addr[ADDR_W-1:OFF_W] == bsrQ);

  // R3: low access operands never leave bank 0
  p_access_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_ACCESS && !operand[OFF_W-1]) |-> addr < (1 << (OFF_W-1)));

  // R5: a bank load is visible in the following cycle
  p_bank_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    bankWrEn |=> bsrQ == $past(bankWrData[BANK_W-1:0]));

  // R4: at most one write target per cycle
  p_one_target_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.memWr, ctrl.portaWr, ctrl.portbWr, ctrl.trisWr}));

  // R10: no write strobe without write enable
  p_no_stray_wr_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(ctrl.memWr || ctrl.portaWr || ctrl.portbWr || ctrl.trisWr));

endmodule

// File: rtl/bmu_datapath.sv
module bmu_datapath
  import bmu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  memCtrl_t          ctrl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] portbIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] portaOut,
  output logic [DATA_W-1:0] portbOut,
  output logic [DATA_W-1:0] portbDir
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] memQ;
  logic [DATA_W-1:0] sfrQ;
  logic [DATA_W-1:0] portaQ, portbQ, trisQ;
  rdSrc_e            rdSelQ;
  logic [DATA_W-1:0] portbView;

  assign portbView = (portbIn & trisQ) | (portbQ & ~trisQ);

  always_ff @(posedge clk) begin
    if (ctrl.memWr) mem[addr] <= wrData;
    memQ <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portaQ <= '0;
      portbQ <= '0;
      trisQ  <= '1;
      sfrQ   <= '0;
      rdSelQ <= RD_MEM;
    end else begin
      if (ctrl.portaWr) portaQ <= wrData;
      if (ctrl.portbWr) portbQ <= wrData;
      if (ctrl.trisWr)  trisQ  <= wrData;
      rdSelQ <= ctrl.rdSel;
      unique case (ctrl.rdSel)
        RD_PORTA: sfrQ <= portaQ;
        RD_PORTB: sfrQ <= portbView;
        RD_TRIS:  sfrQ <= trisQ;
        default:  sfrQ <= '0;
      endcase
    end
  end

  assign rdData   = (rdSelQ == RD_MEM) ? memQ : sfrQ;
  assign portaOut = portaQ;
  assign portbOut = portbQ;
  assign portbDir = trisQ;

  // R8: a direction write lands on portbDir one edge later
  p_tris_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.trisWr |=> portbDir == $past(wrData));

  // R7: the port latch only moves on its own write strobe
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.portbWr |=> $stable(portbOut));

  // R6: PORTA latch only moves on its own write strobe
  p_porta_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.portaWr |=> $stable(portaOut));

endmodule

// File: rtl/banked_mem_unit.sv
module banked_mem_unit
  import bmu_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int OFF_W     = 8,
  parameter int DATA_W    = 8,
  parameter int BANK_IN_W = 8,
  parameter int PTR_IN_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           mode,
  input  logic [OFF_W-1:0]     operand,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 bankWrEn,
  input  logic [BANK_IN_W-1:0] bankWrData,
  input  logic                 ptrWrEn,
  input  logic [PTR_IN_W-1:0]  ptrWrData,
  input  logic [DATA_W-1:0]    portbIn,
  output logic [DATA_W-1:0]    portaOut,
  output logic [DATA_W-1:0]    portbOut,
  output logic [DATA_W-1:0]    portbDir
);

  logic [ADDR_W-1:0] addr;
  memCtrl_t          ctrl;

  bmu_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_IN_W(BANK_IN_W), .PTR_IN_W(PTR_IN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .operand(operand), .wrEn(wrEn),
    .bankWrEn(bankWrEn), .bankWrData(bankWrData),
    .ptrWrEn(ptrWrEn), .ptrWrData(ptrWrData),
    .addr(addr), .ctrl(ctrl)
  );

  bmu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .ctrl(ctrl), .wrData(wrData),
    .portbIn(portbIn), .rdData(rdData), .portaOut(portaOut),
    .portbOut(portbOut), .portbDir(portbDir)
  );

endmodule

// File: tb/banked_mem_unit_tb.sv
`timescale 1ns/100ps
module banked_mem_unit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  mode;
  logic [7:0]  operand;
  logic        wrEn;
  logic [7:0]  wrData;
  logic [7:0]  rdData;
  logic        bankWrEn;
  logic [7:0]  bankWrData;
  logic        ptrWrEn;
  logic [15:0] ptrWrData;
  logic [7:0]  portbIn;
  logic [7:0]  portaOut, portbOut, portbDir;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdValid = 1'b0;
  logic       capValid = 1'b0;

  always #2.5 clk = ~clk;

  banked_mem_unit u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .operand(operand), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .bankWrEn(bankWrEn), .bankWrData(bankWrData),
    .ptrWrEn(ptrWrEn), .ptrWrData(ptrWrData), .portbIn(portbIn),
    .portaOut(portaOut), .portbOut(portbOut), .portbDir(portbDir)
  );

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: the read issued in the previous cycle is compared mid-cycle.
  always @(posedge clk) capValid <= rdValid;
  always @(negedge clk) begin
    if (capValid && expQ.size() > 0) begin
      check8(rdData, expQ.pop_front(), tagQ.pop_front());
    end
  end

  task automatic idle();
    wrEn = 1'b0; bankWrEn = 1'b0; ptrWrEn = 1'b0; rdValid = 1'b0;
  endtask

  task automatic doWrite(input logic [1:0] m, input logic [7:0] op, input logic [7:0] d);
    @(posedge clk); #1;
    mode = m; operand = op; wrData = d; wrEn = 1'b1; rdValid = 1'b0;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic doRead(input logic [1:0] m, input logic [7:0] op,
                        input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    mode = m; operand = op; wrEn = 1'b0; rdValid = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(posedge clk); #1;
    idle();
  endtask

  task automatic doReadWrite(input logic [1:0] m, input logic [7:0] op, input logic [7:0] d,
                             input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    mode = m; operand = op; wrData = d; wrEn = 1'b1; rdValid = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(posedge clk); #1;
    idle();
  endtask

  task automatic loadBank(input logic [7:0] v);
    @(posedge clk); #1;
    bankWrData = v; bankWrEn = 1'b1;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic loadPtr(input logic [15:0] v);
    @(posedge clk); #1;
    ptrWrData = v; ptrWrEn = 1'b1;
    @(posedge clk); #1;
    idle();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; mode = 2'b00; operand = '0; wrData = '0; bankWrData = '0;
    ptrWrData = '0; portbIn = 8'h3C;
    idle();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // Reset state
    check8(portbDir, 8'hFF, "R8 direction reset");
    check8(portaOut, 8'h00, "R6 PORTA reset");
    check8(portbOut, 8'h00, "R7 PORTB reset");

    // R5: bank register resets to zero, so direct 10h is address 010h, same as access 10h
    doWrite(2'b00, 8'h10, 8'h5A);
    doRead(2'b10, 8'h10, 8'h5A, "R5 bank reset zero / R3 access low");

    // R1 / R2 / R5: upper bits of the loads are ignored
    loadBank(8'h35);
    doWrite(2'b00, 8'h22, 8'hA1);           // address 522h
    loadPtr(16'hF522);
    doRead(2'b01, 8'h00, 8'hA1, "R2 indirect via pointer");
    doRead(2'b00, 8'h22, 8'hA1, "R1 direct with bank 5");

    // R3: access high half lands in bank 15 while bank 5 is selected
    doWrite(2'b10, 8'h85, 8'h77);           // address F85h
    loadBank(8'hAF);
    doRead(2'b00, 8'h85, 8'h77, "R3 access high maps to F85h");

    // R9: spare mode behaves as direct (bank 15 -> F40h)
    doWrite(2'b11, 8'h40, 8'h3C);
    loadPtr(16'h0F40);
    doRead(2'b01, 8'h00, 8'h3C, "R9 spare mode as direct");

    // R10: wrEn low leaves the byte unchanged
    @(posedge clk); #1;
    mode = 2'b01; wrData = 8'hEE; wrEn = 1'b0;
    @(posedge clk); #1;
    idle();
    doRead(2'b01, 8'h00, 8'h3C, "R10 no write without enable");

    // R4: read during write returns the old byte, then the new one
    doReadWrite(2'b01, 8'h00, 8'h99, 8'h3C, "R4 read-during-write old data");
    doRead(2'b01, 8'h00, 8'h99, "R4 written data");

    // R6: PORTA at F80h
    doWrite(2'b10, 8'h80, 8'hC3);
    check8(portaOut, 8'hC3, "R6 PORTA latch drives output");
    doRead(2'b10, 8'h80, 8'hC3, "R6 PORTA read");

    // R8: direction register at F93h
    doWrite(2'b10, 8'h93, 8'h0F);
    check8(portbDir, 8'h0F, "R8 direction write");
    doRead(2'b10, 8'h93, 8'h0F, "R8 direction read");

    // R7: PORTB at F81h, mixed read
    doWrite(2'b10, 8'h81, 8'hA5);
    check8(portbOut, 8'hA5, "R7 PORTB latch drives output");
    doRead(2'b10, 8'h81, (8'h3C & 8'h0F) | (8'hA5 & 8'hF0), "R7 PORTB mixed read");

    // R10: PORTB latch not touched when wrEn is low
    @(posedge clk); #1;
    mode = 2'b10; operand = 8'h81; wrData = 8'h00; wrEn = 1'b0;
    @(posedge clk); #1;
    idle();
    check8(portbOut, 8'hA5, "R10 PORTB latch held");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule